// File: doc/BRIEF.md
# Single-Bus Register-Transfer Datapath

This block is the data side of a small processor in which every transfer between storage elements travels over one shared internal bus. It contains a bank of general registers, a program counter, an instruction register, a scratch register, an ALU operand latch (Y), an ALU result latch (Z), a memory address register and a memory data register. An external sequencer supplies one control word per clock. The control word sets which single source drives the bus, which destinations capture it, what the ALU does, and whether a memory read or write is started. The sequencer itself is not part of this block.

A typical operation takes several control steps. For example, a register-to-register add moves one operand into Y, then drives the other operand while the ALU adds Y to the bus and Z captures the sum, then moves Z to the destination. The memory side uses a completion handshake. A request raises a level that stays high until the memory answers with a one-cycle function-completed strobe. Because the control word is accepted every cycle and memory waits use that completion strobe, there is no valid/ready interface and no back-pressure. A sequencer that waits for memory simply keeps issuing the same control word until the strobe arrives.

Top module: `sbus_datapath`

## Requirements
- R1: While reset is asserted (asynchronous, active low), every storage register returns to zero, and `mem_rd`, `mem_wr`, `done` and `bus_err` are low.
- R2: `bus_obs` carries the value of the one source whose out-enable is asserted. With no out-enable asserted it is zero.
- R3: On a rising clock edge, every register whose in-enable is high captures `bus_obs`. A register whose in-enable is low keeps its value.
- R4: The ALU takes operand A from Y when `sel_const`=0 and from the constant 4 when `sel_const`=1, and takes operand B from the bus. `alu_op` 2'b00 gives A+B+cin, 2'b01 gives A+~B+cin, 2'b10 gives A^B and 2'b11 passes B. Z captures the result only when `z_in` is high.
- R5: A three-step sequence (source 1 into Y; source 2 on the bus with add into Z; Z into the destination) leaves the destination holding the modulo-2^32 sum and both sources unchanged.
- R6: Driving the PC with `sel_const`=1 and add into Z, then moving Z into the PC, advances the PC by 4.
- R7: `mem_addr` always shows the memory address register, which captures the bus when `mar_in` is high.
- R8: `mem_rd_req` makes `mem_rd` high from the next cycle on, and it stays high until the edge after `mem_mfc` is sampled high. The data register captures `mem_rdata` on an edge where `mdr_in_e` and `mem_mfc` are both high, and this memory-side load takes priority over `mdr_in`. If `mdr_in_e` is high without `mem_mfc`, the data register is left unchanged.
- R9: `mem_wr_req` makes `mem_wr` high from the next cycle on, and it stays high until the edge after `mem_mfc`. `mem_wdata` shows the data register while `mdr_out_e` is high and is zero otherwise.
- R10: `bus_err` is high in any cycle in which two or more out-enables are asserted, and low otherwise.
- R11: `done` is high for exactly the one cycle that follows a cycle with `end_step` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpr_out | input | NGPR | Per-general-register bus drive enables |
| gpr_in | input | NGPR | Per-general-register bus capture enables |
| pc_out | input | 1 | PC drives bus |
| pc_in | input | 1 | PC captures bus |
| ir_out | input | 1 | Instruction register drives bus |
| ir_in | input | 1 | Instruction register captures bus |
| tmp_out | input | 1 | Scratch register drives bus |
| tmp_in | input | 1 | Scratch register captures bus |
| y_in | input | 1 | Y latch captures bus |
| z_in | input | 1 | Z latch captures ALU result |
| z_out | input | 1 | Z drives bus |
| mar_in | input | 1 | Address register captures bus |
| mdr_in | input | 1 | Data register captures bus |
| mdr_out | input | 1 | Data register drives bus |
| mdr_in_e | input | 1 | Data register captures memory data on completion |
| mdr_out_e | input | 1 | Data register drives memory write data |
| sel_const | input | 1 | ALU A operand: 0 = Y, 1 = constant 4 |
| alu_op | input | 2 | ALU operation code |
| carry_in | input | 1 | ALU carry input |
| mem_rd_req | input | 1 | Start a memory read |
| mem_wr_req | input | 1 | Start a memory write |
| end_step | input | 1 | Final step of the current sequence |
| mem_rdata | input | DW | Memory read data |
| mem_mfc | input | 1 | Memory function completed strobe |
| mem_addr | output | DW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rd | output | 1 | Read in progress |
| mem_wr | output | 1 | Write in progress |
| bus_obs | output | DW | Current internal bus value |
| ir_word | output | DW | Instruction register contents, for the decoder |
| bus_err | output | 1 | More than one bus driver asserted |
| done | output | 1 | Sequence-end pulse |

## Verification
A wrong value captured in any register stays hidden until a later step drives that register onto the bus. At that point it shows on `bus_obs` within the same cycle, so the bench reads back each destination, and the sources it must not have disturbed, one step after the transfer. Faults in the handshake show on `mem_rd`/`mem_wr` one cycle after the request or the completion strobe. A faulty conflict detector shows on `bus_err` combinationally, in the very cycle of the bad control word.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic [1:0] {
    ALU_ADD   = 2'b00,
    ALU_SUB   = 2'b01,
    ALU_XOR   = 2'b10,
    ALU_PASSB = 2'b11
  } alu_op_e;

  localparam int unsigned PC_STEP = 4;
endpackage

// File: rtl/sbus_ldreg.sv
module sbus_ldreg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/sbus_gprs.sv
module sbus_gprs #(
  parameter int DW   = 32,
  parameter int NGPR = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   bus,
  input  logic [NGPR-1:0] in_en,
  input  logic [NGPR-1:0] out_en,
  output logic [DW-1:0]   drv
);
  logic [DW-1:0] regs [NGPR];

  for (genvar g = 0; g < NGPR; g++) begin : g_reg
    sbus_ldreg #(.DW(DW)) u_r (
      .clk(clk), .rst_n(rst_n), .ld(in_en[g]), .d(bus), .q(regs[g])
    );
  end

  // AND-OR contribution of the enabled registers to the bus
  always_comb begin
    drv = '0;
    for (int i = 0; i < NGPR; i++) begin
      if (out_en[i]) drv = drv | regs[i];
    end
  end
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] y_val,
  input  logic          sel_const,
  input  logic [DW-1:0] b_val,
  input  logic [1:0]    op,
  input  logic          cin,
  output logic [DW-1:0] res
);
  localparam logic [DW-1:0] KSTEP = DW'(PC_STEP);

  logic [DW-1:0] a_val;
  logic [DW-1:0] cin_w;

  assign a_val = sel_const ? KSTEP : y_val;
  assign cin_w = {{(DW-1){1'b0}}, cin};

  always_comb begin
    unique case (alu_op_e'(op))
      ALU_ADD:   res = a_val + b_val + cin_w;
      ALU_SUB:   res = a_val + ~b_val + cin_w;
      ALU_XOR:   res = a_val ^ b_val;
      default:   res = b_val;
    endcase
  end
endmodule

// File: rtl/sbus_mdr.sv
module sbus_mdr #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus,
  input  logic          ld_bus,
  input  logic          ld_mem,
  input  logic          drv_mem,
  input  logic          mfc,
  input  logic [DW-1:0] rdata,
  input  logic          rd_req,
  input  logic          wr_req,
  output logic [DW-1:0] q,
  output logic          rd_pend,
  output logic          wr_pend,
  output logic [DW-1:0] wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= '0;
      rd_pend <= 1'b0;
      wr_pend <= 1'b0;
    end else begin
      // memory-side capture wins over internal-side capture
      if (ld_mem && mfc) q <= rdata;
      else if (ld_bus)   q <= bus;
      rd_pend <= rd_req | (rd_pend & ~mfc);
      wr_pend <= wr_req | (wr_pend & ~mfc);
    end
  end

  assign wdata = drv_mem ? q : '0;
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath #(
  parameter int DW   = 32,
  parameter int NGPR = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NGPR-1:0] gpr_out,
  input  logic [NGPR-1:0] gpr_in,
  input  logic            pc_out,
  input  logic            pc_in,
  input  logic            ir_out,
  input  logic            ir_in,
  input  logic            tmp_out,
  input  logic            tmp_in,
  input  logic            y_in,
  input  logic            z_in,
  input  logic            z_out,
  input  logic            mar_in,
  input  logic            mdr_in,
  input  logic            mdr_out,
  input  logic            mdr_in_e,
  input  logic            mdr_out_e,
  input  logic            sel_const,
  input  logic [1:0]      alu_op,
  input  logic            carry_in,
  input  logic            mem_rd_req,
  input  logic            mem_wr_req,
  input  logic            end_step,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_mfc,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [DW-1:0]   bus_obs,
  output logic [DW-1:0]   ir_word,
  output logic            bus_err,
  output logic            done
);
  localparam int NSRC = NGPR + 5;

  logic [DW-1:0]   bus, gpr_drv, alu_res;
  logic [DW-1:0]   pc_q, ir_q, tmp_q, y_q, z_q, mar_q, mdr_q;
  logic [NSRC-1:0] out_vec;

  assign out_vec = {ir_out, mdr_out, z_out, tmp_out, pc_out, gpr_out};

  sbus_gprs #(.DW(DW), .NGPR(NGPR)) u_gprs (
    .clk(clk), .rst_n(rst_n), .bus(bus),
    .in_en(gpr_in), .out_en(gpr_out), .drv(gpr_drv)
  );

  sbus_ldreg #(.DW(DW)) u_pc  (.clk(clk), .rst_n(rst_n), .ld(pc_in),  .d(bus),     .q(pc_q));
  sbus_ldreg #(.DW(DW)) u_ir  (.clk(clk), .rst_n(rst_n), .ld(ir_in),  .d(bus),     .q(ir_q));
  sbus_ldreg #(.DW(DW)) u_tmp (.clk(clk), .rst_n(rst_n), .ld(tmp_in), .d(bus),     .q(tmp_q));
  sbus_ldreg #(.DW(DW)) u_y   (.clk(clk), .rst_n(rst_n), .ld(y_in),   .d(bus),     .q(y_q));
  sbus_ldreg #(.DW(DW)) u_z   (.clk(clk), .rst_n(rst_n), .ld(z_in),   .d(alu_res), .q(z_q));
  sbus_ldreg #(.DW(DW)) u_mar (.clk(clk), .rst_n(rst_n), .ld(mar_in), .d(bus),     .q(mar_q));

  sbus_alu #(.DW(DW)) u_alu (
    .y_val(y_q), .sel_const(sel_const), .b_val(bus),
    .op(alu_op), .cin(carry_in), .res(alu_res)
  );

  sbus_mdr #(.DW(DW)) u_mdr (
    .clk(clk), .rst_n(rst_n), .bus(bus),
    .ld_bus(mdr_in), .ld_mem(mdr_in_e), .drv_mem(mdr_out_e),
    .mfc(mem_mfc), .rdata(mem_rdata),
    .rd_req(mem_rd_req), .wr_req(mem_wr_req),
    .q(mdr_q), .rd_pend(mem_rd), .wr_pend(mem_wr), .wdata(mem_wdata)
  );

  // shared bus: AND-OR of all enabled sources, zero when idle
  always_comb begin
    bus = gpr_drv;
    if (pc_out)  bus = bus | pc_q;
    if (ir_out)  bus = bus | ir_q;
    if (tmp_out) bus = bus | tmp_q;
    if (z_out)   bus = bus | z_q;
    if (mdr_out) bus = bus | mdr_q;
  end

  // drive-conflict detection
  always_comb begin
    logic seen;
    seen    = 1'b0;
    bus_err = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (out_vec[i]) begin
        if (seen) bus_err = 1'b1;
        seen = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= end_step;
  end

  assign bus_obs  = bus;
  assign mem_addr = mar_q;
  assign ir_word  = ir_q;
endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk #(
  parameter int DW   = 32,
  parameter int NSRC = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] out_vec,
  input logic            bus_err,
  input logic            mem_rd_req,
  input logic            mem_rd,
  input logic            mem_wr_req,
  input logic            mem_wr,
  input logic            mem_mfc,
  input logic            end_step,
  input logic            done,
  input logic            mar_in,
  input logic            z_in,
  input logic [DW-1:0]   bus_obs,
  input logic [DW-1:0]   mem_addr,
  input logic [DW-1:0]   z_q
);
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!mem_rd && !mem_wr && !done));

  a_r10_conflict_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(out_vec) > 1) |-> bus_err);

  a_r10_no_false_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(out_vec) <= 1) |-> !bus_err);

  a_r8_read_starts: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> mem_rd);

  a_r8_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_mfc) |=> mem_rd);

  a_r9_write_starts: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |=> mem_wr);

  a_r9_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_mfc) |=> mem_wr);

  a_r11_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    end_step |=> done);

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    !end_step |=> !done);

  a_r7_address_capture: assert property (@(posedge clk) disable iff (!rst_n)
    mar_in |=> (mem_addr == $past(bus_obs)));

  a_r4_z_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !z_in |=> $stable(z_q));
endmodule

bind sbus_datapath sbus_datapath_chk #(.DW(DW), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_vec(out_vec), .bus_err(bus_err),
  .mem_rd_req(mem_rd_req), .mem_rd(mem_rd),
  .mem_wr_req(mem_wr_req), .mem_wr(mem_wr), .mem_mfc(mem_mfc),
  .end_step(end_step), .done(done), .mar_in(mar_in), .z_in(z_in),
  .bus_obs(bus_obs), .mem_addr(mem_addr), .z_q(z_q)
);

// File: tb/test_sbus_datapath.sv
module test_sbus_datapath;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int NGPR = 4;
  localparam int SRC_PC = 4, SRC_TMP = 5, SRC_Z = 6, SRC_MDR = 7, SRC_IR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NGPR-1:0] gpr_out, gpr_in;
  logic pc_out, pc_in, ir_out, ir_in, tmp_out, tmp_in, y_in, z_in, z_out;
  logic mar_in, mdr_in, mdr_out, mdr_in_e, mdr_out_e, sel_const, carry_in;
  logic [1:0] alu_op;
  logic mem_rd_req, mem_wr_req, end_step, mem_mfc;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] mem_addr, mem_wdata, bus_obs, ir_word;
  logic mem_rd, mem_wr, bus_err, done;

  int n_cmp = 0;
  int n_bad = 0;
  logic probe_v = 1'b0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic [DW-1:0] r [NGPR];

  always #(CLK_PERIOD/2) clk = ~clk;

  sbus_datapath #(.DW(DW), .NGPR(NGPR)) i_sbus_datapath (
    .clk(clk), .rst_n(rst_n), .gpr_out(gpr_out), .gpr_in(gpr_in),
    .pc_out(pc_out), .pc_in(pc_in), .ir_out(ir_out), .ir_in(ir_in),
    .tmp_out(tmp_out), .tmp_in(tmp_in), .y_in(y_in), .z_in(z_in), .z_out(z_out),
    .mar_in(mar_in), .mdr_in(mdr_in), .mdr_out(mdr_out),
    .mdr_in_e(mdr_in_e), .mdr_out_e(mdr_out_e), .sel_const(sel_const),
    .alu_op(alu_op), .carry_in(carry_in), .mem_rd_req(mem_rd_req),
    .mem_wr_req(mem_wr_req), .end_step(end_step), .mem_rdata(mem_rdata),
    .mem_mfc(mem_mfc), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .bus_obs(bus_obs), .ir_word(ir_word),
    .bus_err(bus_err), .done(done)
  );

  task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    gpr_out = '0; gpr_in = '0;
    pc_out = 0; pc_in = 0; ir_out = 0; ir_in = 0; tmp_out = 0; tmp_in = 0;
    y_in = 0; z_in = 0; z_out = 0; mar_in = 0; mdr_in = 0; mdr_out = 0;
    mdr_in_e = 0; mdr_out_e = 0; sel_const = 0; carry_in = 0; alu_op = 2'b00;
    mem_rd_req = 0; mem_wr_req = 0; end_step = 0; mem_mfc = 0;
  endtask

  // next control step: wait for the falling edge and clear the control word
  task automatic nx();
    @(negedge clk);
    clr();
    probe_v = 1'b0;
  endtask

  task automatic drive_src(input int src);
    if (src < NGPR) gpr_out[src] = 1'b1;
    else if (src == SRC_PC)  pc_out = 1'b1;
    else if (src == SRC_TMP) tmp_out = 1'b1;
    else if (src == SRC_Z)   z_out = 1'b1;
    else if (src == SRC_MDR) mdr_out = 1'b1;
    else                     ir_out = 1'b1;
  endtask

  // driver: one step that places a source on the bus and queues its expected value
  task automatic probe(input int src, input logic [DW-1:0] exp, input string tag);
    nx();
    drive_src(src);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    probe_v = 1'b1;
  endtask

  // monitor: compares the bus against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (probe_v) begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_obs === e, t, bus_obs, e);
      end
    end
  end

  task automatic load_gpr(input int idx, input logic [DW-1:0] v);
    nx(); mem_rd_req = 1;
    nx(); #1 chk(mem_rd === 1'b1, "R8 read pending", {31'b0, mem_rd}, 1);
    mdr_in_e = 1; mem_mfc = 1; mem_rdata = v;
    nx(); #1 chk(mem_rd === 1'b0, "R8 read released", {31'b0, mem_rd}, 0);
    mdr_out = 1; gpr_in[idx] = 1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    summary();
  end

  initial begin
    logic [DW-1:0] zv;
    clr();
    mem_rdata = '0;
    r[0] = 32'h8000_0001; r[1] = 32'h0000_00F0;
    r[2] = 32'h1234_5678; r[3] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    nx(); #1;
    chk(!mem_rd && !mem_wr && !done && !bus_err, "R1 flags", {28'b0, mem_rd, mem_wr, done, bus_err}, 0);
    chk(mem_addr === '0, "R1 address", mem_addr, 0);
    chk(ir_word === '0, "R1 ir", ir_word, 0);
    chk(bus_obs === '0, "R2 idle bus", bus_obs, 0);
    for (int i = 0; i < NGPR; i++) probe(i, '0, "R1 gpr zero");
    probe(SRC_PC, '0, "R1 pc zero");
    probe(SRC_Z, '0, "R1 z zero");
    probe(SRC_MDR, '0, "R1 mdr zero");

    // R3/R8 load all general registers through memory reads
    for (int i = 0; i < NGPR; i++) load_gpr(i, r[i]);
    for (int i = 0; i < NGPR; i++) probe(i, r[i], "R3 gpr loaded");

    // R5 three-step add: R3 <- R1 + R2
    nx(); gpr_out[1] = 1; y_in = 1;
    nx(); gpr_out[2] = 1; alu_op = 2'b00; z_in = 1;
    nx(); z_out = 1; gpr_in[3] = 1;
    r[3] = r[1] + r[2];
    probe(3, r[3], "R5 sum");
    probe(1, r[1], "R5 src1 kept");
    probe(2, r[2], "R5 src2 kept");

    // R4 subtract with carry-in 1: Y=R0, B=R1
    nx(); gpr_out[0] = 1; y_in = 1;
    nx(); gpr_out[1] = 1; alu_op = 2'b01; carry_in = 1; z_in = 1;
    zv = r[0] - r[1];
    probe(SRC_Z, zv, "R4 sub");

    // R4 Z holds when z_in low
    nx(); gpr_out[2] = 1; alu_op = 2'b00;
    probe(SRC_Z, zv, "R4 z hold");

    // R4 xor: Y=R2, B=R1
    nx(); gpr_out[2] = 1; y_in = 1;
    nx(); gpr_out[1] = 1; alu_op = 2'b10; z_in = 1;
    probe(SRC_Z, r[2] ^ r[1], "R4 xor");

    // R4 add with carry-in: Y=R1, B=R1
    nx(); gpr_out[1] = 1; y_in = 1;
    nx(); gpr_out[1] = 1; alu_op = 2'b00; carry_in = 1; z_in = 1;
    probe(SRC_Z, r[1] + r[1] + 1, "R4 add carry");

    // R4 constant operand with pass-B and add
    nx(); gpr_out[3] = 1; sel_const = 1; alu_op = 2'b11; z_in = 1;
    probe(SRC_Z, r[3], "R4 pass B");
    nx(); gpr_out[3] = 1; sel_const = 1; alu_op = 2'b00; z_in = 1;
    probe(SRC_Z, r[3] + 4, "R4 const four");

    // R6 PC advance twice
    for (int k = 1; k <= 2; k++) begin
      nx(); pc_out = 1; sel_const = 1; alu_op = 2'b00; z_in = 1;
      nx(); z_out = 1; pc_in = 1;
      probe(SRC_PC, 32'(4 * k), "R6 pc step");
    end

    // R3 instruction and scratch registers
    nx(); gpr_out[2] = 1; ir_in = 1; tmp_in = 1;
    nx(); #1 chk(ir_word === r[2], "R3 ir load", ir_word, r[2]);
    probe(SRC_TMP, r[2], "R3 tmp load");
    probe(SRC_IR, r[2], "R2 ir drives bus");

    // R7 address register
    nx(); gpr_out[1] = 1; mar_in = 1;
    nx(); #1 chk(mem_addr === r[1], "R7 mem_addr", mem_addr, r[1]);

    // R9 write handshake
    nx(); gpr_out[0] = 1; mdr_in = 1; mem_wr_req = 1;
    nx(); #1 chk(mem_wr === 1'b1, "R9 write pending", {31'b0, mem_wr}, 1);
    chk(mem_wdata === '0, "R9 wdata idle", mem_wdata, 0);
    mdr_out_e = 1; #1 chk(mem_wdata === r[0], "R9 wdata driven", mem_wdata, r[0]);
    nx(); #1 chk(mem_wr === 1'b1, "R9 write held", {31'b0, mem_wr}, 1);
    mdr_out_e = 1; mem_mfc = 1;
    nx(); #1 chk(mem_wr === 1'b0, "R9 write released", {31'b0, mem_wr}, 0);

    // R8 memory-side enable without completion leaves MDR
    nx(); mdr_in_e = 1; mem_rdata = 32'hDEAD_BEEF;
    probe(SRC_MDR, r[0], "R8 no mfc no load");
    // R8 memory side wins over internal side
    nx(); gpr_out[1] = 1; mdr_in = 1; mdr_in_e = 1; mem_mfc = 1; mem_rdata = 32'hCAFE_0042;
    probe(SRC_MDR, 32'hCAFE_0042, "R8 priority");

    // R10 conflict flag
    nx(); gpr_out[0] = 1; gpr_out[1] = 1;
    #1 chk(bus_err === 1'b1, "R10 two drivers", {31'b0, bus_err}, 1);
    nx(); z_out = 1; pc_out = 1; gpr_out[3] = 1;
    #1 chk(bus_err === 1'b1, "R10 three drivers", {31'b0, bus_err}, 1);
    nx(); pc_out = 1;
    #1 chk(bus_err === 1'b0, "R10 single driver", {31'b0, bus_err}, 0);

    // R11 end pulse
    nx(); end_step = 1;
    #1 chk(done === 1'b0, "R11 not yet", {31'b0, done}, 0);
    nx(); #1 chk(done === 1'b1, "R11 pulse", {31'b0, done}, 1);
    nx(); #1 chk(done === 1'b0, "R11 one cycle", {31'b0, done}, 0);

    nx();
    nx();
    chk(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 0);
    summary();
  end
endmodule